// File: doc/BRIEF.md
# Shared-Peripheral Power Sequencer with Use Counting

This block decides when a peripheral that several clients share is powered. Each client raises a one-cycle `get_i` pulse when it starts needing the peripheral and a one-cycle `put_i` pulse when it is done. The block counts these requests. The count going from zero to one starts a power-up. The count returning to zero starts a power-down. All other requests change only the count.

Power-up turns the rails on in a fixed order, one step per clock:
1. the I/O domain,
2. the power partition,
3. the clock,
4. a timed engine reset: a hold lasting a set number of milliseconds, then a settle period.

If `keep_alive_i` shows that the downstream engine is already running, the reset step is skipped, so the engine is not disturbed. Power-down releases the rails in the reverse order. `ready_o` is high only while the peripheral is fully up and settled.

The millisecond delays come from a clock-frequency parameter. A division parameter lets a simulation shrink them. Requests are never stalled: a request that arrives during a sequence is counted at once, and any transition it implies starts after the running sequence ends. All pins are plain control and status pins, and there is no back-pressure.

Top module: `pwr_refcount_seq`

## Requirements
- R1: Two cycles after the `get_i` pulse that moves the count from 0 to 1, `io_en_o` rises. `part_en_o` rises one cycle later, and `clk_en_o` rises one cycle after that.
- R2: Unless skipped, `eng_rst_o` rises the cycle after `clk_en_o` and stays high for RESET_MS milliseconds (RESET_MS × cycles-per-ms cycles). `ready_o` then rises SETTLE_MS milliseconds after `eng_rst_o` falls.
- R3: If `keep_alive_i` is high in the cycle after `clk_en_o` rises, `eng_rst_o` never pulses and `ready_o` rises on the next cycle.
- R4: Two cycles after the `put_i` pulse that moves the count from 1 to 0, `clk_en_o` and `ready_o` fall. `part_en_o` falls one cycle later, and `io_en_o` falls one cycle after that.
- R5: A `get_i` or `put_i` that does not cross zero changes `use_count_o` by one and changes no rail or `ready_o`.
- R6: A lone `put_i` while the count is 0 sets `underflow_o`, which then stays high until reset, and leaves the count at 0.
- R7: A lone `get_i` while the count is at its maximum (2^CNT_W − 1) sets the sticky `overflow_o` and leaves the count unchanged.
- R8: A request that arrives during a sequence is counted at once. A power-down implied by it starts the cycle after `ready_o` rises. A power-up implied by it starts (`io_en_o` rises) the cycle after `io_en_o` falls.
- R9: `ready_o` is high only while all three enables are high and `eng_rst_o` is low.
- R10: `get_i` and `put_i` high in the same cycle leave the count, the rails and both error flags unchanged.
- R11: After reset, all outputs are low and `use_count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| get_i | input | 1 | One-cycle request to take a use |
| put_i | input | 1 | One-cycle request to drop a use |
| keep_alive_i | input | 1 | Engine already running; skip the reset step |
| io_en_o | output | 1 | I/O domain enable |
| part_en_o | output | 1 | Power partition un-gate |
| clk_en_o | output | 1 | Peripheral clock enable |
| eng_rst_o | output | 1 | Engine reset, active high |
| ready_o | output | 1 | Peripheral powered and settled |
| use_count_o | output | CNT_W | Current use count |
| underflow_o | output | 1 | Sticky: put seen at count 0 |
| overflow_o | output | 1 | Sticky: get seen at maximum count |

## Verification
The bench builds the block with CLK_HZ = 100 MHz and TIME_DIV = 10000, which makes one millisecond 10 cycles. With these values the 2 ms reset hold is 20 cycles and the 1 ms settle is 10 cycles, so exact edge cycles can be predicted and compared for full sequences, including the cases where a request overlaps a running sequence. CNT_W = 3 brings the saturation point down to 7, so the overflow case is reached in a few pulses.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [3:0] {
    PS_OFF,
    PS_UP_IO,
    PS_UP_PART,
    PS_UP_CLK,
    PS_RST_HOLD,
    PS_RST_WAIT,
    PS_ON,
    PS_DN_CLK,
    PS_DN_PART
  } pwr_state_e;

  typedef struct packed {
    logic ready;
    logic eng_rst;
    logic clk_en;
    logic part_en;
    logic io_en;
  } pwr_rail_t;

  // cycles for a delay of ms milliseconds, never below one
  function automatic longint unsigned ms_to_cycles(longint unsigned hz,
                                                   longint unsigned div,
                                                   longint unsigned ms);
    longint unsigned c;
    c = ((hz / 64'd1000) * ms) / div;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic pwr_rail_t rails_of(pwr_state_e s);
    pwr_rail_t r;
    r = '0;
    r.io_en   = (s != PS_OFF);
    r.part_en = (s inside {PS_UP_PART, PS_UP_CLK, PS_RST_HOLD, PS_RST_WAIT,
                           PS_ON, PS_DN_CLK});
    r.clk_en  = (s inside {PS_UP_CLK, PS_RST_HOLD, PS_RST_WAIT, PS_ON});
    r.eng_rst = (s == PS_RST_HOLD);
    r.ready   = (s == PS_ON);
    return r;
  endfunction

endpackage

// File: rtl/pwrseq_use_counter.sv
module pwrseq_use_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             get_i,
  input  logic             put_i,
  output logic [CNT_W-1:0] count_o,
  output logic             nonzero_o,
  output logic             underflow_o,
  output logic             overflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;
  logic             udf_q, ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      udf_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      unique case ({get_i, put_i})
        2'b10: begin
          if (count_q == CNT_MAX) ovf_q <= 1'b1;
          else                    count_q <= count_q + 1'b1;
        end
        2'b01: begin
          if (count_q == '0) udf_q <= 1'b1;
          else               count_q <= count_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign count_o     = count_q;
  assign nonzero_o   = (count_q != '0);
  assign underflow_o = udf_q;
  assign overflow_o  = ovf_q;
endmodule

// File: rtl/pwrseq_ms_timer.sv
module pwrseq_ms_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int TMR_W    = 8,
  parameter int HOLD_CYC = 2,
  parameter int WAIT_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_use_i,
  input  logic             keep_alive_i,
  input  logic             tmr_expired_i,
  output logic             tmr_load_o,
  output logic [TMR_W-1:0] tmr_val_o,
  output pwr_rail_t        rails_o
);
  localparam logic [TMR_W-1:0] HOLD_LD = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] WAIT_LD = TMR_W'(WAIT_CYC - 1);

  pwr_state_e state_q, state_d;
  pwr_rail_t  rails_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      PS_OFF:      if (in_use_i) state_d = PS_UP_IO;
      PS_UP_IO:    state_d = PS_UP_PART;
      PS_UP_PART:  state_d = PS_UP_CLK;
      PS_UP_CLK: begin
        if (keep_alive_i) begin
          state_d = PS_ON;
        end else begin
          state_d    = PS_RST_HOLD;
          tmr_load_o = 1'b1;
          tmr_val_o  = HOLD_LD;
        end
      end
      PS_RST_HOLD: begin
        if (tmr_expired_i) begin
          state_d    = PS_RST_WAIT;
          tmr_load_o = 1'b1;
          tmr_val_o  = WAIT_LD;
        end
      end
      PS_RST_WAIT: if (tmr_expired_i) state_d = PS_ON;
      PS_ON:       if (!in_use_i) state_d = PS_DN_CLK;
      PS_DN_CLK:   state_d = PS_DN_PART;
      PS_DN_PART:  state_d = PS_OFF;
      default:     state_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OFF;
      rails_q <= '0;
    end else begin
      state_q <= state_d;
      rails_q <= rails_of(state_d);
    end
  end

  assign rails_o = rails_q;
endmodule

// File: rtl/pwr_refcount_seq.sv
module pwr_refcount_seq
  import pwrseq_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 100_000_000,
  parameter longint unsigned TIME_DIV  = 1,
  parameter int              RESET_MS  = 2,
  parameter int              SETTLE_MS = 1,
  parameter int              CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             get_i,
  input  logic             put_i,
  input  logic             keep_alive_i,
  output logic             io_en_o,
  output logic             part_en_o,
  output logic             clk_en_o,
  output logic             eng_rst_o,
  output logic             ready_o,
  output logic [CNT_W-1:0] use_count_o,
  output logic             underflow_o,
  output logic             overflow_o
);
  localparam int HOLD_CYC = int'(ms_to_cycles(CLK_HZ, TIME_DIV, RESET_MS));
  localparam int WAIT_CYC = int'(ms_to_cycles(CLK_HZ, TIME_DIV, SETTLE_MS));
  localparam int MAX_CYC  = (HOLD_CYC > WAIT_CYC) ? HOLD_CYC : WAIT_CYC;
  localparam int TMR_W    = $clog2(MAX_CYC + 1) + 1;

  logic             in_use;
  logic             tmr_load, tmr_expired;
  logic [TMR_W-1:0] tmr_val;
  pwr_rail_t        rails;

  pwrseq_use_counter #(.CNT_W(CNT_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .get_i       (get_i),
    .put_i       (put_i),
    .count_o     (use_count_o),
    .nonzero_o   (in_use),
    .underflow_o (underflow_o),
    .overflow_o  (overflow_o)
  );

  pwrseq_ms_timer #(.TMR_W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  pwrseq_fsm #(
    .TMR_W    (TMR_W),
    .HOLD_CYC (HOLD_CYC),
    .WAIT_CYC (WAIT_CYC)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_use_i      (in_use),
    .keep_alive_i  (keep_alive_i),
    .tmr_expired_i (tmr_expired),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .rails_o       (rails)
  );

  assign io_en_o   = rails.io_en;
  assign part_en_o = rails.part_en;
  assign clk_en_o  = rails.clk_en;
  assign eng_rst_o = rails.eng_rst;
  assign ready_o   = rails.ready;
endmodule

// File: rtl/pwr_refcount_seq_chk.sv
module pwr_refcount_seq_chk
  import pwrseq_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 100_000_000,
  parameter longint unsigned TIME_DIV  = 1,
  parameter int              RESET_MS  = 2,
  parameter int              SETTLE_MS = 1,
  parameter int              CNT_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             get_i,
  input logic             put_i,
  input logic             keep_alive_i,
  input logic             io_en_o,
  input logic             part_en_o,
  input logic             clk_en_o,
  input logic             eng_rst_o,
  input logic             ready_o,
  input logic [CNT_W-1:0] use_count_o,
  input logic             underflow_o,
  input logic             overflow_o
);
  localparam int HOLD_CYC = int'(ms_to_cycles(CLK_HZ, TIME_DIV, RESET_MS));

  logic [31:0] hold_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_run <= '0;
    else if (eng_rst_o) hold_run <= hold_run + 1;
    else                hold_run <= '0;
  end

  assert_rail_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_o |-> part_en_o) and (part_en_o |-> io_en_o));

  assert_reset_under_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst_o |-> clk_en_o);

  assert_hold_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_rst_o && hold_run != 0) |-> (hold_run == HOLD_CYC));

  assert_ready_full_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (io_en_o && part_en_o && clk_en_o && !eng_rst_o));

  assert_idle_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!get_i && !put_i) |=> $stable(use_count_o));

  assert_cancel_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (get_i && put_i) |=> $stable(use_count_o));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (put_i && !get_i && use_count_o == '0) |=> (underflow_o && use_count_o == '0));

  assert_underflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> underflow_o);

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  assert_down_clock_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(part_en_o) |-> !clk_en_o);
endmodule

bind pwr_refcount_seq pwr_refcount_seq_chk #(
  .CLK_HZ    (CLK_HZ),
  .TIME_DIV  (TIME_DIV),
  .RESET_MS  (RESET_MS),
  .SETTLE_MS (SETTLE_MS),
  .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/test_pwr_refcount_seq.sv
module test_pwr_refcount_seq;
  localparam int CNT_W = 3;
  localparam int HOLD  = 20;
  localparam int SETL  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic get_i = 1'b0, put_i = 1'b0, keep_alive_i = 1'b0;
  logic io_en_o, part_en_o, clk_en_o, eng_rst_o, ready_o;
  logic [CNT_W-1:0] use_count_o;
  logic underflow_o, overflow_o;

  always #5 clk = ~clk;

  pwr_refcount_seq #(
    .CLK_HZ(100_000_000), .TIME_DIV(10_000), .RESET_MS(2), .SETTLE_MS(1),
    .CNT_W(CNT_W)
  ) i_pwr_refcount_seq (.*);

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; logic [4:0] vec; string req; } ev_t;
  ev_t exp_q[$];

  // vec = {ready, eng_rst, clk_en, part_en, io_en}
  task automatic push_ev(int at, logic [4:0] vec, string req);
    ev_t e;
    e.at = at; e.vec = vec; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: every change of the rail vector must match the next expected item
  logic [4:0] prev_vec = '0;
  always @(negedge clk) begin
    logic [4:0] now;
    now = {ready_o, eng_rst_o, clk_en_o, part_en_o, io_en_o};
    if (rst_n && now !== prev_vec) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected rail change at %0d actual %b expected none", cyc, now);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        if (e.at != cyc || e.vec !== now) begin
          errors++;
          $display("FAIL %s rail event actual cyc %0d vec %b expected cyc %0d vec %b",
                   e.req, cyc, now, e.at, e.vec);
        end
      end
    end
    prev_vec = now;
  end

  task automatic pulse_at(int c, bit g, bit p);
    while (cyc < c) @(negedge clk);
    get_i = g; put_i = p;
    @(negedge clk);
    get_i = 1'b0; put_i = 1'b0;
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic push_up(int g, string req);
    push_ev(g + 2, 5'b00001, req);
    push_ev(g + 3, 5'b00011, req);
    push_ev(g + 4, 5'b00111, req);
    push_ev(g + 5, 5'b01111, "R2");
    push_ev(g + 5 + HOLD, 5'b00111, "R2");
    push_ev(g + 5 + HOLD + SETL, 5'b10111, "R2");
  endtask

  task automatic push_down(int p, string req);
    push_ev(p + 2, 5'b00011, req);
    push_ev(p + 3, 5'b00001, req);
    push_ev(p + 4, 5'b00000, req);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected 0", cyc);
    summary();
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    // R11 reset state
    check({io_en_o, part_en_o, clk_en_o, eng_rst_o, ready_o, underflow_o, overflow_o} == 0,
          "R11", "outputs in reset", 1, 0);
    check(use_count_o == 0, "R11", "count in reset", use_count_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 full power-up
    t = cyc; push_up(t, "R1"); pulse_at(t, 1, 0);
    check(use_count_o == 1, "R1", "count after first get", use_count_o, 1);
    wait_to(t + 40);
    check(ready_o == 1, "R2", "ready after power-up", ready_o, 1);

    // R5 non-crossing requests
    pulse_at(cyc, 1, 0); pulse_at(cyc, 1, 0);
    check(use_count_o == 3, "R5", "count after two more gets", use_count_o, 3);
    pulse_at(cyc, 0, 1); pulse_at(cyc, 0, 1);
    check(use_count_o == 1, "R5", "count after two puts", use_count_o, 1);
    // R10 simultaneous while up
    pulse_at(cyc, 1, 1);
    check(use_count_o == 1, "R10", "count after get+put", use_count_o, 1);
    check(ready_o == 1, "R5", "ready kept", ready_o, 1);

    // R4 power-down
    t = cyc; push_down(t, "R4"); pulse_at(t, 0, 1);
    wait_to(t + 8);
    check(use_count_o == 0, "R4", "count after last put", use_count_o, 0);

    // R10 at zero: no flag, no change
    pulse_at(cyc, 1, 1);
    check(use_count_o == 0 && underflow_o == 0 && overflow_o == 0, "R10",
          "count/flags after get+put at zero", use_count_o, 0);

    // R6 underflow
    pulse_at(cyc, 0, 1);
    check(underflow_o == 1, "R6", "underflow flag", underflow_o, 1);
    check(use_count_o == 0, "R6", "count held at zero", use_count_o, 0);
    wait_to(cyc + 3);
    check(underflow_o == 1, "R6", "underflow sticky", underflow_o, 1);

    // R3 keep-alive skips reset
    keep_alive_i = 1'b1;
    t = cyc;
    push_ev(t + 2, 5'b00001, "R3");
    push_ev(t + 3, 5'b00011, "R3");
    push_ev(t + 4, 5'b00111, "R3");
    push_ev(t + 5, 5'b10111, "R3");
    pulse_at(t, 1, 0);
    wait_to(t + 8);
    check(ready_o == 1, "R3", "ready without reset", ready_o, 1);
    keep_alive_i = 1'b0;
    t = cyc; push_down(t, "R4"); pulse_at(t, 0, 1);
    wait_to(t + 8);

    // R8 put during power-up: down starts after ready
    t = cyc;
    push_up(t, "R8");
    push_down(t + 34, "R8");
    pulse_at(t, 1, 0);
    pulse_at(t + 3, 0, 1);
    wait_to(t + 45);
    check(use_count_o == 0, "R8", "count after overlapping put", use_count_o, 0);
    check(io_en_o == 0, "R8", "powered down after deferral", io_en_o, 0);

    // R8 get during power-down: up restarts after io off
    t = cyc; push_up(t, "R1"); pulse_at(t, 1, 0);
    wait_to(t + 40);
    t = cyc;
    push_down(t, "R4");
    push_up(t + 3, "R8");
    pulse_at(t, 0, 1);
    pulse_at(t + 2, 1, 0);
    wait_to(t + 45);
    check(ready_o == 1, "R8", "ready after deferred power-up", ready_o, 1);

    // R7 overflow at maximum
    for (int i = 0; i < 6; i++) pulse_at(cyc, 1, 0);
    check(use_count_o == 7 && overflow_o == 0, "R7", "count at max", use_count_o, 7);
    pulse_at(cyc, 1, 0);
    check(overflow_o == 1, "R7", "overflow flag", overflow_o, 1);
    check(use_count_o == 7, "R7", "count held at max", use_count_o, 7);

    wait_to(cyc + 5);
    check(exp_q.size() == 0, "R1", "missing rail events", exp_q.size(), 0);
    summary();
  end
endmodule